// File: doc/BRIEF.md
# Divide-By-Zero Default Result Generator

This block sits beside the divider of an extended-precision floating-point unit. It handles the case where a finite non-zero value is divided by zero. The unit uses an 80-bit word: a sign bit at bit 79, a 15-bit biased exponent in bits 78:64, and a 64-bit significand in bits 63:0 whose top bit is the explicit integer bit. When a valid request meets that condition, the block raises a divide-by-zero flag. If the exception is masked, it also supplies the special value that replaces the normal quotient. If it is unmasked, it writes nothing, so the stack and its pointer stay as they were.

The special value depends on the operation class:
- Plain divide and reverse divide return an infinity. Its sign is the XOR of the two operand signs.
- The multiply-by-logarithm class returns an infinity signed opposite to its non-zero operand.
- The exponent/significand extraction class writes two results. A signed zero goes to the top slot, negative infinity goes to the slot below it, and the stack grows by one.

A small state machine holds the outcome of the previous request in one of three states:
- `ST_IDLE`: no condition.
- `ST_MASKED`: default written.
- `ST_TRAP`: flag only.

Its transitions are taken on each clock:
- `GO_IDLE` when there is no valid request or the condition is absent.
- `GO_MASKED` when the condition holds and the mask bit is set.
- `GO_TRAP` when the condition holds and the mask bit is clear.

The result words are registered alongside the state.

Top module: `dz_default_gen`

## Requirements
- R1: All outputs are registered with one cycle of latency from `in_valid`. A cycle with `in_valid` low gives all outputs zero in the following cycle, and reset gives all outputs zero.
- R2: With `op_sel`=0 (divide, `opa` dividend, `opb` divisor), a finite non-zero `opa` and a zero `opb` raise the condition. The masked result is `res0` = infinity with sign `opa[79]` XOR `opb[79]`.
- R3: With `op_sel`=1 (reverse divide, `opb` dividend, `opa` divisor), a finite non-zero `opb` and a zero `opa` raise the condition. The masked result is `res0` = infinity with sign `opa[79]` XOR `opb[79]`.
- R4: With `op_sel`=2 (logarithm class, `opa` multiplier, `opb` log argument), a finite non-zero `opa` and a zero `opb` raise the condition. The masked result is `res0` = infinity with sign NOT `opa[79]`.
- R5: With `op_sel`=3 (extract, source `opa`, `opb` ignored), a zero `opa` raises the condition. The masked result is `res0` = zero carrying the sign of `opa`, `res1` = negative infinity, with `res0_we`, `res1_we` and `stk_push` all high.
- R6: For `op_sel` 0 to 2, a zero dividend with a zero divisor does not raise the condition: `dz_flag` and all write enables stay low.
- R7: A dividend with an all-ones exponent (infinity or NaN), or a non-zero divisor, does not raise the condition.
- R8: When the condition holds and `dz_mask` is 0, `dz_flag` is 1 while `res0_we`, `res1_we` and `stk_push` are 0.
- R9: Infinity is encoded as exponent all ones with significand 0x8000_0000_0000_0000. Zero is encoded as exponent and significand all zero. An operand with exponent 0 and a non-zero significand counts as finite non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| op_sel | input | 2 | Operation class: 0 divide, 1 reverse divide, 2 logarithm, 3 extract |
| dz_mask | input | 1 | 1 = divide-by-zero exception masked |
| opa | input | 80 | First operand |
| opb | input | 80 | Second operand |
| res0 | output | 80 | Result for the top stack slot |
| res0_we | output | 1 | Write enable for `res0` |
| res1 | output | 80 | Result for the slot below the top (extract only) |
| res1_we | output | 1 | Write enable for `res1` |
| stk_push | output | 1 | Stack grows by one (masked extract) |
| dz_flag | output | 1 | Divide-by-zero condition seen |

## Verification
The condition needs exact zeros, so it is almost never reached by operands drawn uniformly at random. The same holds for the excluded zero-by-zero case and for denormal dividends. The stimulus therefore builds each operand from a small pool of class representatives: signed zeros, denormals, normals, infinities and NaNs. It then crosses that pool with every operation class and both mask settings. Directed vectors open the run to pin down each sign rule and the two-slot extract result.

// File: rtl/dzg_pkg.sv
package dzg_pkg;

    localparam int DZG_EXP_W = 15;
    localparam int DZG_SIG_W = 64;

    typedef enum logic [1:0] {
        OPC_DIV  = 2'd0,
        OPC_RDIV = 2'd1,
        OPC_LOG  = 2'd2,
        OPC_XTR  = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MASKED = 2'd1,
        ST_TRAP   = 2'd2
    } dz_state_e;

endpackage

// File: rtl/dzg_classify.sv
module dzg_classify #(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64
) (
    input  logic [EXP_W+SIG_W:0] word,
    output logic                 sign,
    output logic                 is_zero,
    output logic                 is_fin_nz
);
    localparam int WORD_W = 1 + EXP_W + SIG_W;

    logic [EXP_W-1:0] exp_f;
    logic [SIG_W-1:0] sig_f;

    always_comb begin
        sign      = word[WORD_W-1];
        exp_f     = word[WORD_W-2:SIG_W];
        sig_f     = word[SIG_W-1:0];
        is_zero   = (exp_f == '0) && (sig_f == '0);
        is_fin_nz = (exp_f != '1) && !is_zero;
    end
endmodule

// File: rtl/dzg_select.sv
module dzg_select
    import dzg_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64
) (
    input  op_class_e            op,
    input  logic                 a_sign,
    input  logic                 a_zero,
    input  logic                 a_fnz,
    input  logic                 b_sign,
    input  logic                 b_zero,
    input  logic                 b_fnz,
    output logic                 cond,
    output logic                 two_dst,
    output logic [EXP_W+SIG_W:0] r0,
    output logic [EXP_W+SIG_W:0] r1
);
    localparam int WORD_W = 1 + EXP_W + SIG_W;

    function automatic logic [WORD_W-1:0] inf_word(input logic s);
        return {s, {EXP_W{1'b1}}, 1'b1, {(SIG_W-1){1'b0}}};
    endfunction

    always_comb begin
        cond    = 1'b0;
        two_dst = 1'b0;
        r0      = '0;
        r1      = '0;
        unique case (op)
            OPC_DIV: begin
                cond = a_fnz && b_zero;
                r0   = inf_word(a_sign ^ b_sign);
            end
            OPC_RDIV: begin
                cond = b_fnz && a_zero;
                r0   = inf_word(a_sign ^ b_sign);
            end
            OPC_LOG: begin
                cond = a_fnz && b_zero;
                r0   = inf_word(!a_sign);
            end
            OPC_XTR: begin
                cond    = a_zero;
                two_dst = 1'b1;
                r0      = {a_sign, {(WORD_W-1){1'b0}}};
                r1      = inf_word(1'b1);
            end
        endcase
    end
endmodule

// File: rtl/dz_default_gen.sv
module dz_default_gen
    import dzg_pkg::*;
#(
    parameter int EXP_W = DZG_EXP_W,
    parameter int SIG_W = DZG_SIG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [1:0]           op_sel,
    input  logic                 dz_mask,
    input  logic [EXP_W+SIG_W:0] opa,
    input  logic [EXP_W+SIG_W:0] opb,
    output logic [EXP_W+SIG_W:0] res0,
    output logic                 res0_we,
    output logic [EXP_W+SIG_W:0] res1,
    output logic                 res1_we,
    output logic                 stk_push,
    output logic                 dz_flag
);
    localparam int WORD_W = 1 + EXP_W + SIG_W;
    localparam int N_OPS  = 2;

    logic [WORD_W-1:0] ops [N_OPS];
    logic [N_OPS-1:0]  op_sign, op_zero, op_fnz;

    assign ops[0] = opa;
    assign ops[1] = opb;

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
        dzg_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) i_cls (
            .word     (ops[gi]),
            .sign     (op_sign[gi]),
            .is_zero  (op_zero[gi]),
            .is_fin_nz(op_fnz[gi])
        );
    end

    op_class_e         op_c;
    logic              cond, two_dst;
    logic [WORD_W-1:0] sel_r0, sel_r1;

    assign op_c = op_class_e'(op_sel);

    dzg_select #(.EXP_W(EXP_W), .SIG_W(SIG_W)) i_sel (
        .op     (op_c),
        .a_sign (op_sign[0]),
        .a_zero (op_zero[0]),
        .a_fnz  (op_fnz[0]),
        .b_sign (op_sign[1]),
        .b_zero (op_zero[1]),
        .b_fnz  (op_fnz[1]),
        .cond   (cond),
        .two_dst(two_dst),
        .r0     (sel_r0),
        .r1     (sel_r1)
    );

    dz_state_e         state_q, state_d;
    logic              two_q;
    logic [WORD_W-1:0] r0_q, r1_q;

    // next-state selection: GO_IDLE / GO_MASKED / GO_TRAP
    always_comb begin
        if (in_valid && cond)
            state_d = dz_mask ? ST_MASKED : ST_TRAP;
        else
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_d != ST_MASKED) begin
            r0_q  <= '0;
            r1_q  <= '0;
            two_q <= 1'b0;
        end else begin
            r0_q  <= sel_r0;
            r1_q  <= sel_r1;
            two_q <= two_dst;
        end
    end

    always_comb begin
        res0     = r0_q;
        res1     = r1_q;
        res0_we  = 1'b0;
        res1_we  = 1'b0;
        stk_push = 1'b0;
        dz_flag  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_MASKED: begin
                dz_flag  = 1'b1;
                res0_we  = 1'b1;
                res1_we  = two_q;
                stk_push = two_q;
            end
            ST_TRAP: dz_flag = 1'b1;
            default: ;
        endcase
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!dz_flag && !res0_we && !res1_we));

    // R8
    trap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dz_mask) |=> (!res0_we && !res1_we && !stk_push));

    // R6
    zero_by_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_zero[0] && op_zero[1] && op_sel != 2'd3) |=> !dz_flag);

    // R2
    div_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dz_mask && op_sel == 2'd0 && op_fnz[0] && op_zero[1])
        |=> (res0_we && res0[WORD_W-1] == ($past(opa[WORD_W-1]) ^ $past(opb[WORD_W-1]))));

    // R5
    xtr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res1_we |-> (res0_we && stk_push && res1[WORD_W-1] && res0[WORD_W-2:0] == '0));
endmodule

// File: tb/test_dz_default_gen.sv
module test_dz_default_gen;
    localparam int CLK_PERIOD = 10;
    localparam int W = 80;

    typedef struct {
        logic         flag, we0, we1, push;
        logic [W-1:0] r0, r1;
        string        tag;
    } exp_t;

    logic         clk = 0, rst_n = 0, in_valid = 0, dz_mask = 0;
    logic [1:0]   op_sel = 0;
    logic [W-1:0] opa = 0, opb = 0;
    logic [W-1:0] res0, res1;
    logic         res0_we, res1_we, stk_push, dz_flag;

    int n_vec = 0, n_bad = 0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dz_default_gen i_dz_default_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .dz_mask(dz_mask), .opa(opa), .opb(opb),
        .res0(res0), .res0_we(res0_we), .res1(res1), .res1_we(res1_we),
        .stk_push(stk_push), .dz_flag(dz_flag));

    // R9 encodings
    localparam logic [W-1:0] POS_INF = {1'b0, 15'h7fff, 64'h8000_0000_0000_0000};
    localparam logic [W-1:0] NEG_INF = {1'b1, 15'h7fff, 64'h8000_0000_0000_0000};

    function automatic logic [W-1:0] mk(input int k, input logic s);
        case (k)
            0: return {s, 79'd0};                                     // zero
            1: return {s, 15'h0000, 64'h0000_0000_0000_0123};         // denormal (R9)
            2: return {s, 15'h3fff, 64'h8000_0000_0000_0000};         // one
            3: return {s, 15'h4005, 64'hc123_4567_89ab_cdef};         // normal
            4: return {s, 15'h7fff, 64'h8000_0000_0000_0000};         // infinity (R7)
            default: return {s, 15'h7fff, 64'hc000_0000_0000_0001};   // NaN (R7)
        endcase
    endfunction

    function automatic exp_t model(input logic v, input logic [1:0] op,
                                   input logic m, input logic [W-1:0] a,
                                   input logic [W-1:0] b);
        exp_t e;
        logic az, bz, af, bf, c;
        e = '{flag:0, we0:0, we1:0, push:0, r0:'0, r1:'0, tag:"R1"};
        az = (a[78:0] == '0);
        bz = (b[78:0] == '0);
        af = (a[78:64] != 15'h7fff) && !az;
        bf = (b[78:64] != 15'h7fff) && !bz;
        if (!v) return e;
        case (op)
            2'd0: begin c = af && bz; e.tag = "R2"; e.r0 = (a[79]^b[79]) ? NEG_INF : POS_INF; end
            2'd1: begin c = bf && az; e.tag = "R3"; e.r0 = (a[79]^b[79]) ? NEG_INF : POS_INF; end
            2'd2: begin c = af && bz; e.tag = "R4"; e.r0 = a[79] ? POS_INF : NEG_INF; end
            default: begin c = az; e.tag = "R5"; e.r0 = {a[79], 79'd0}; e.r1 = NEG_INF; end
        endcase
        if (op != 2'd3 && az && bz) e.tag = "R6";
        if (!c) begin
            if (e.tag != "R6") e.tag = "R7";
            e.r0 = '0; e.r1 = '0;
            return e;
        end
        e.flag = 1;
        if (!m) begin
            e.tag = "R8"; e.r0 = '0; e.r1 = '0;
            return e;
        end
        e.we0 = 1;
        e.we1 = (op == 2'd3);
        e.push = e.we1;
        return e;
    endfunction

    task automatic drive(input logic v, input logic [1:0] op, input logic m,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        in_valid = v; op_sel = op; dz_mask = m; opa = a; opb = b;
        sb.push_back(model(v, op, m, a, b));
    endtask

    // monitor: one item per cycle, sampled 1 time unit after the edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (dz_flag !== e.flag || res0_we !== e.we0 || res1_we !== e.we1 ||
                stk_push !== e.push || (e.we0 && res0 !== e.r0) ||
                (e.we1 && res1 !== e.r1)) begin
                n_bad++;
                $display("FAIL %s: got flag=%b we0=%b we1=%b push=%b r0=%h r1=%h exp flag=%b we0=%b we1=%b push=%b r0=%h r1=%h",
                    e.tag, dz_flag, res0_we, res1_we, stk_push, res0, res1,
                    e.flag, e.we0, e.we1, e.push, e.r0, e.r1);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got running exp finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_vec++;
        if (dz_flag || res0_we || res1_we || stk_push || res0 != 0 || res1 != 0) begin
            n_bad++;
            $display("FAIL R1: got flag=%b we0=%b exp all zero after reset", dz_flag, res0_we);
        end
        rst_n = 1;
        // R2 divide signs
        drive(1, 2'd0, 1, mk(3, 0), mk(0, 1));
        drive(1, 2'd0, 1, mk(3, 1), mk(0, 1));
        drive(1, 2'd0, 1, mk(1, 1), mk(0, 0));   // R9 denormal dividend
        // R3 reverse divide
        drive(1, 2'd1, 1, mk(0, 0), mk(2, 1));
        drive(1, 2'd1, 1, mk(0, 1), mk(2, 1));
        // R4 logarithm class
        drive(1, 2'd2, 1, mk(2, 0), mk(0, 1));
        drive(1, 2'd2, 1, mk(3, 1), mk(0, 0));
        // R5 extract, both zero signs, opb ignored
        drive(1, 2'd3, 1, mk(0, 1), mk(5, 0));
        drive(1, 2'd3, 1, mk(0, 0), mk(3, 1));
        drive(1, 2'd3, 1, mk(2, 0), mk(0, 0));
        // R6 zero by zero
        drive(1, 2'd0, 1, mk(0, 0), mk(0, 1));
        drive(1, 2'd1, 1, mk(0, 1), mk(0, 1));
        drive(1, 2'd2, 1, mk(0, 0), mk(0, 0));
        // R7 infinite / NaN dividend, non-zero divisor
        drive(1, 2'd0, 1, mk(4, 0), mk(0, 0));
        drive(1, 2'd0, 1, mk(5, 1), mk(0, 0));
        drive(1, 2'd0, 1, mk(3, 0), mk(1, 0));
        // R8 unmasked
        drive(1, 2'd0, 0, mk(3, 0), mk(0, 0));
        drive(1, 2'd3, 0, mk(0, 1), mk(0, 0));
        // R1 idle cycle with a condition-like operand pair
        drive(0, 2'd0, 1, mk(3, 0), mk(0, 0));
        // cross of operand classes
        for (int i = 0; i < 3000; i++) begin
            drive($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)),
                  1'($urandom_range(0, 1)),
                  mk($urandom_range(0, 5), 1'($urandom_range(0, 1))),
                  mk($urandom_range(0, 5), 1'($urandom_range(0, 1))));
        end
        drive(0, 2'd0, 0, '0, '0);
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule